// File: doc/BRIEF.md
# Serial-Loaded Multichannel PWM Bank

This block drives a row of independent pulse-width-modulated outputs, intended for LED brightness control. A host streams every channel's duty value in one continuous serial frame over a three-wire time-slot bus: a bit strobe, a frame marker and a data line. There are no addressed register writes. A slot counter counts the incoming bits. Its upper bits pick the channel, and its lower bits pick the bit position inside that channel's duty byte.

Received bytes collect in a shadow bank. The shadow bank is copied into the active bank only at the instant the shared PWM counter rolls over from its top value to zero, so every PWM period uses one consistent set of duty values. A single counter, stepped by an external prescaler tick, is compared against each active duty value to form each output.

The host sets the tick rate so that one full 256-step period fits inside the display refresh budget, which is about 10 ms. It also starts its frames in step with its colour-mixing intervals of about 3 ms.

Top module: `pwm_bank_top`

## Requirements
- R1: After synchronous reset, the slot counter, the PWM counter and both duty banks are zero, so every output is low.
- R2: Each cycle with `sbit_valid` high and `sbit_sync` low advances the slot counter by one. After the last bit of a frame (slot 255 by default) it wraps to slot 0, so an extra bit overwrites channel 0 starting at its MSB.
- R3: `sbit_sync` restarts the frame. If it comes alone, the next valid bit lands in slot 0. If it comes together with `sbit_valid`, that bit itself is slot 0.
- R4: Slot k writes channel k[7:3], bit 7 − k[2:0]. Each channel's byte is therefore sent MSB first, and channel 0 comes first in the frame.
- R5: The active duty bank loads the whole shadow bank only on a `pwm_tick` cycle in which the PWM counter is 255. At any other time, incoming bits leave the outputs unchanged.
- R6: The PWM counter advances by one on each `pwm_tick` cycle, holds when `pwm_tick` is low, and wraps from 255 to 0.
- R7: `pwm_out[c]` is high exactly while the PWM counter is less than channel c's active duty. Duty 0 is never high, and duty 255 is high for 255 of 256 steps.
- R8: Every channel follows only its own duty value, so one frame can give all channels different brightness levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sbit_valid | input | 1 | Strobe: one serial duty bit is present this cycle |
| sbit_sync | input | 1 | Frame marker: restart the slot counter |
| sbit_data | input | 1 | Serial duty bit value |
| pwm_tick | input | 1 | Prescaler enable: step the PWM counter |
| pwm_out | output | NUM_CH (32) | Per-channel PWM outputs |

## Verification
The bound checker checks these on every cycle: the slot counter's step, hold and restart on each valid bit or frame marker; the PWM counter's step and hold on the tick; that the active bank stays frozen everywhere except at the rollover tick, where it takes the shadow contents; that reset clears the outputs; and that a zero duty keeps its output low. Only the bench scenarios can show that bits reach the correct channel in MSB-first order. The same holds for the high-time of each channel over a full period matching its duty value, for the overflow bit wrapping onto channel 0, and for a mid-frame restart discarding partial data.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int DEF_CH     = 32;
    localparam int DEF_DUTY_W = 8;

    // One beat of the serial time-slot bus
    typedef struct packed {
        logic valid;
        logic sync;
        logic data;
    } ser_beat_t;

    function automatic int clog2i(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return (r == 0) ? 1 : r;
    endfunction
endpackage

// File: rtl/slot_deserializer.sv
module slot_deserializer
    import pwm_pkg::*;
#(
    parameter int NUM_CH = DEF_CH,
    parameter int DUTY_W = DEF_DUTY_W,
    localparam int CH_W  = clog2i(NUM_CH),
    localparam int SEL_W = clog2i(DUTY_W),
    localparam int CNT_W = CH_W + SEL_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  ser_beat_t                      beat,
    output logic [CNT_W-1:0]               slot_q,
    output logic [NUM_CH-1:0][DUTY_W-1:0]  shadow_q
);
    logic [CNT_W-1:0] slot_idx;
    logic [CH_W-1:0]  ch_sel;
    logic [SEL_W-1:0] bit_sel;

    always_comb begin
        slot_idx = beat.sync ? '0 : slot_q;
        ch_sel   = slot_idx[CNT_W-1:SEL_W];
        bit_sel  = SEL_W'(DUTY_W - 1) - slot_idx[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            shadow_q <= '0;
        end else if (beat.valid) begin
            shadow_q[ch_sel][bit_sel] <= beat.data;
            slot_q <= slot_idx + 1'b1;
        end else if (beat.sync) begin
            slot_q <= '0;
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int DUTY_W = DEF_DUTY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [DUTY_W-1:0] cnt_q,
    output logic              wrap_stb
);
    assign wrap_stb = tick && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_compare_array.sv
module pwm_compare_array
    import pwm_pkg::*;
#(
    parameter int NUM_CH = DEF_CH,
    parameter int DUTY_W = DEF_DUTY_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [NUM_CH-1:0][DUTY_W-1:0] shadow,
    input  logic [DUTY_W-1:0]             cnt,
    output logic [NUM_CH-1:0][DUTY_W-1:0] active_q,
    output logic [NUM_CH-1:0]             outs
);
    always_ff @(posedge clk) begin
        if (rst)       active_q <= '0;
        else if (load) active_q <= shadow;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign outs[c] = (cnt < active_q[c]);
    end
endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top
    import pwm_pkg::*;
#(
    parameter int NUM_CH = DEF_CH,
    parameter int DUTY_W = DEF_DUTY_W,
    localparam int CNT_W = clog2i(NUM_CH) + clog2i(DUTY_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sbit_valid,
    input  logic              sbit_sync,
    input  logic              sbit_data,
    input  logic              pwm_tick,
    output logic [NUM_CH-1:0] pwm_out
);
    ser_beat_t                     beat;
    logic [CNT_W-1:0]              slot_q;
    logic [NUM_CH-1:0][DUTY_W-1:0] shadow_q;
    logic [NUM_CH-1:0][DUTY_W-1:0] active_q;
    logic [DUTY_W-1:0]             pwm_cnt;
    logic                          wrap_stb;

    assign beat = '{valid: sbit_valid, sync: sbit_sync, data: sbit_data};

    slot_deserializer #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_deser (
        .clk(clk), .rst(rst), .beat(beat),
        .slot_q(slot_q), .shadow_q(shadow_q)
    );

    pwm_timebase #(.DUTY_W(DUTY_W)) u_tb (
        .clk(clk), .rst(rst), .tick(pwm_tick),
        .cnt_q(pwm_cnt), .wrap_stb(wrap_stb)
    );

    pwm_compare_array #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_cmp (
        .clk(clk), .rst(rst), .load(wrap_stb), .shadow(shadow_q),
        .cnt(pwm_cnt), .active_q(active_q), .outs(pwm_out)
    );
endmodule

// File: rtl/pwm_bank_checker.sv
module pwm_bank_checker #(
    parameter int NUM_CH = 32,
    parameter int DUTY_W = 8,
    parameter int CNT_W  = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          sbit_valid,
    input logic                          sbit_sync,
    input logic                          pwm_tick,
    input logic [CNT_W-1:0]              slot_q,
    input logic [DUTY_W-1:0]             pwm_cnt,
    input logic [NUM_CH-1:0][DUTY_W-1:0] shadow_q,
    input logic [NUM_CH-1:0][DUTY_W-1:0] active_q,
    input logic [NUM_CH-1:0]             pwm_out
);
    a_r1_reset_outputs_low: assert property (@(posedge clk)
        rst |=> (pwm_out == '0));

    a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
        (sbit_valid && !sbit_sync) |=> (slot_q == $past(slot_q) + 1'b1));

    a_r2_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (!sbit_valid && !sbit_sync) |=> $stable(slot_q));

    a_r3_sync_alone: assert property (@(posedge clk) disable iff (rst)
        (sbit_sync && !sbit_valid) |=> (slot_q == '0));

    a_r3_sync_with_bit: assert property (@(posedge clk) disable iff (rst)
        (sbit_sync && sbit_valid) |=> (slot_q == CNT_W'(1)));

    a_r5_active_frozen: assert property (@(posedge clk) disable iff (rst)
        !(pwm_tick && (pwm_cnt == '1)) |=> $stable(active_q));

    a_r5_active_load: assert property (@(posedge clk) disable iff (rst)
        (pwm_tick && (pwm_cnt == '1)) |=> (active_q == $past(shadow_q)));

    a_r6_cnt_step: assert property (@(posedge clk) disable iff (rst)
        pwm_tick |=> (pwm_cnt == $past(pwm_cnt) + 1'b1));

    a_r6_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        !pwm_tick |=> $stable(pwm_cnt));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_zero
        a_r7_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
            (active_q[c] == '0) |-> !pwm_out[c]);
    end
endmodule

bind pwm_bank_top pwm_bank_checker #(
    .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .sbit_valid(sbit_valid), .sbit_sync(sbit_sync),
    .pwm_tick(pwm_tick), .slot_q(slot_q), .pwm_cnt(pwm_cnt),
    .shadow_q(shadow_q), .active_q(active_q), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_bank_top.sv
module sim_pwm_bank_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sbit_valid = 1'b0;
    logic sbit_sync = 1'b0;
    logic sbit_data = 1'b0;
    logic pwm_tick = 1'b0;
    logic [NCH-1:0] pwm_out;

    int n_tests = 0;
    int n_fail = 0;
    int ticks_sent = 0;
    int hist [NCH];
    int exp_d [NCH];
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank_top u0 (
        .clk(clk), .rst(rst), .sbit_valid(sbit_valid), .sbit_sync(sbit_sync),
        .sbit_data(sbit_data), .pwm_tick(pwm_tick), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: inputs set just after a falling edge, consumed by the next rising edge
    task automatic cyc(input bit t, input bit v, input bit s, input bit d);
        pwm_tick = t; sbit_valid = v; sbit_sync = s; sbit_data = d;
        @(negedge clk);
        pwm_tick = 1'b0; sbit_valid = 1'b0; sbit_sync = 1'b0; sbit_data = 1'b0;
        if (t) ticks_sent++;
    endtask

    function automatic int pat(input int sel, input int ch);
        case (sel)
            0: pat = (ch == 0) ? 0 : (ch == NCH-1) ? 255 : ch * 8;
            1: pat = 255 - ch * 8;
            default: pat = (ch * 53 + 17) & 255;
        endcase
    endfunction

    task automatic send_byte(input int v, input bit first_sync);
        for (int b = 7; b >= 0; b--)
            cyc(1'b0, 1'b1, (b == 7) && first_sync, v[b]);
    endtask

    task automatic send_frame(input int sel, input bit coincident_sync);
        for (int c = 0; c < NCH; c++) begin
            send_byte(pat(sel, c), (c == 0) && coincident_sync);
            exp_d[c] = pat(sel, c);
        end
    endtask

    // tick until the counter has rolled over to 0 (copy happens on that tick)
    task automatic align_wrap();
        int n;
        n = 256 - (ticks_sent % 256);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    // count high steps for each channel over one full period starting at 0
    task automatic measure();
        for (int c = 0; c < NCH; c++) hist[c] = 0;
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < NCH; c++) if (pwm_out[c]) hist[c]++;
            cyc(1'b1, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic check_duties(input string req);
        for (int c = 0; c < NCH; c++)
            chk(hist[c] == exp_d[c], req, hist[c], exp_d[c]);
    endtask

    task automatic t_reset();
        chk(pwm_out == '0, "R1 outputs low after reset", int'(pwm_out), 0);
        for (int c = 0; c < NCH; c++) exp_d[c] = 0;
        measure();
        check_duties("R1 duty zero after reset");
    endtask

    task automatic t_load_basic();
        send_frame(0, 1'b1);
        align_wrap();
        measure();
        check_duties("R4 R7 R8 pattern0 with 0 and 255");
        chk(hist[0] == 0, "R7 duty0 never high", hist[0], 0);
        chk(hist[NCH-1] == 255, "R7 duty255 high 255 of 256", hist[NCH-1], 255);
    endtask

    task automatic t_shadow_hold();
        logic [NCH-1:0] ref_out;
        for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        ref_out = pwm_out;
        for (int c = 0; c < NCH; c++)
            chk(ref_out[c] == (100 < exp_d[c]), "R7 compare at count 100",
                int'(ref_out[c]), int'(100 < exp_d[c]));
        send_frame(1, 1'b1);
        chk(pwm_out == ref_out, "R5 new frame does not reach outputs", int'(pwm_out), int'(ref_out));
        align_wrap();
        measure();
        check_duties("R5 R4 pattern1 after rollover");
    endtask

    task automatic t_tick_hold();
        int c;
        int d;
        c = 5;
        d = exp_d[c];
        for (int i = 0; i < d - 1; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(pwm_out[c] == 1'b1, "R6 R7 high just below duty", int'(pwm_out[c]), 1);
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk(pwm_out[c] == 1'b1, "R6 counter holds without tick", int'(pwm_out[c]), 1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(pwm_out[c] == 1'b0, "R6 R7 low at count equal duty", int'(pwm_out[c]), 0);
        align_wrap();
    endtask

    task automatic t_wrap_overflow();
        send_frame(2, 1'b1);
        send_byte(8'hA5, 1'b0);
        exp_d[0] = 8'hA5;
        align_wrap();
        measure();
        check_duties("R2 extra byte wraps to channel 0");
    endtask

    task automatic t_sync_restart();
        for (int i = 0; i < 100; i++) cyc(1'b0, 1'b1, 1'b0, i[0]);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        send_frame(1, 1'b0);
        align_wrap();
        measure();
        check_duties("R3 lone sync restarts at slot 0");
        for (int i = 0; i < 37; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1);
        send_frame(0, 1'b1);
        align_wrap();
        measure();
        check_duties("R3 coincident sync bit is slot 0");
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_basic();
        t_shadow_hold();
        t_tick_hold();
        t_wrap_overflow();
        t_sync_restart();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule